// File: doc/BRIEF.md
# Double-Buffered Clock Register Interface

This block is the byte-wide register front end of a timekeeping memory. Its address space is 32K bytes. The top eight byte addresses hold the clock registers, and every lower address is passed through to an ordinary RAM port. The host sees a snapshot copy of the time rather than the live counters. While timekeeping runs freely, the copy is reloaded in one step after each counter update, so a read never returns a set of values that is half old and half new.

The control byte holds two halt flags and a six-bit century field. Setting the read-halt flag freezes the copy so that software can read a consistent time, while the counters keep running. Setting the write-halt flag also freezes the copy, and software then loads a new time into the clock bytes. The counter core is not touched until the write-halt flag is cleared. At that point the whole copy, together with the century taken from the clearing write, is handed to the counters as a one-cycle load. The day byte carries a read-only battery-good flag taken from a battery-low input.

The counter core and the battery sensing sit outside this block. The counters flag each update with `cnt_tick` and accept `ld_pulse` with `ld_time` and `ld_century`.

Top module: `tkr_regfile`

## Requirements
- R1: Clock registers decode at byte addresses 7FF8h (control) through 7FFFh. The order is control, seconds, minutes, hours, day, date, month, year. Each clock byte reads back from the snapshot copy. In `cnt_time` and `ld_time`, seconds sit in bits 7:0 and each following register takes the next byte up, with year in bits 55:48.
- R2: An access below 7FF8h asserts `ram_sel`. A write there asserts `ram_we` and passes address and data to the RAM port. A read there returns `ram_rdata`. Clock writes never assert `ram_we`.
- R3: `bus_rdata_oe` is high only while `bus_cs_n` and `bus_oe_n` are low and `bus_we_n` is high. At all other times it is low.
- R4: While both halt flags are clear, a cycle with `cnt_tick` high loads the whole copy, century included, from the counter inputs at the next clock edge. A read in the tick cycle itself still returns the previous values.
- R5: The read-halt flag is control bit 6. While it is set, ticks leave the copy unchanged. After it is cleared, the next tick refreshes every clock byte and the century together.
- R6: The write-halt flag is control bit 7. While it is set, ticks leave the copy unchanged. Writes to clock bytes change only the copy and produce no load pulse.
- R7: A control write with bit 7 at 0 while write-halt is set raises `ld_pulse` for exactly one cycle, starting in the cycle after the write edge. During that pulse, `ld_time` carries the copy and `ld_century` carries bits 5:0 of that write. The copy's century takes the same value.
- R8: A control write that sets bit 7 or bit 6 leaves the stored century unchanged. The control byte reads as {write-halt, read-halt, century[5:0]}.
- R9: A control write that clears the read-halt flag, with write-halt clear, leaves the century unchanged and produces no load pulse.
- R10: Day byte bit 7 reads as the inverse of `batt_low`. Writes to it have no effect.
- R11: After reset, both halt flags are clear, the century and all clock bytes read 00h, and `ld_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | 15 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (00h when not driven) |
| bus_rdata_oe | output | 1 | Read data drive enable |
| ram_sel | output | 1 | RAM access below the clock window |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 15 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| cnt_tick | input | 1 | Counters present new values this cycle |
| cnt_time | input | 56 | Live clock bytes, seconds in the low byte |
| cnt_century | input | 6 | Live century |
| batt_low | input | 1 | Battery below its good level |
| ld_pulse | output | 1 | One-cycle load of new time into the counters |
| ld_time | output | 56 | Time to load, seconds in the low byte |
| ld_century | output | 6 | Century to load |

## Verification
The bench goes after three groups of corner cases. The first is the century rules. A design that rewrote the century whenever a halt flag was set or the read-halt flag was cleared would show the written zero in place of the held century. The second is freezing. A copy that kept following the counters under either halt would return newer seconds than the ones frozen or written, and a refresh that landed in the tick cycle itself would show up in the same-cycle read. The third is the load on write-halt release: the bench counts load pulses and compares their contents, so a load that fired twice, fired on read-halt release or carried stale bytes is reported. Battery flag overlay, RAM pass-through and read-enable gating are also checked at the ports.

// File: rtl/tkr_pkg.sv
// Shared constants for the clock register interface: register indices
// inside the eight-byte clock window and bit positions of the control byte.
package tkr_pkg;
    localparam int BYTE_W   = 8;
    localparam int CENT_W   = 6;
    localparam int IDX_CTRL = 0;
    localparam int IDX_SEC  = 1;
    localparam int IDX_DAY  = 4;
    localparam int IDX_YEAR = 7;
    localparam int WHALT_BIT = 7;
    localparam int RHALT_BIT = 6;
    localparam int BATT_BIT  = 7;
endpackage

// File: rtl/tkr_bus_decode.sv
// Bus decode: turns the CE/OE/WE strobes into a read qualifier and a
// single-cycle write event, and splits the address into the clock window
// or the RAM pass-through. Assumes NUM_CLK_REGS is a power of two, so the
// window is all-ones in the upper address bits.
module tkr_bus_decode #(
    parameter int ADDR_W       = 15,
    parameter int NUM_CLK_REGS = 8,
    localparam int IDX_W       = $clog2(NUM_CLK_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_oe_n,
    input  logic              bus_we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic              in_clk,
    output logic [IDX_W-1:0]  reg_idx,
    output logic              rd_act,
    output logic              wr_fire,
    output logic              clk_wr_fire,
    output logic              ram_sel,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata
);
    logic wr_act;
    logic wr_act_q;

    // Window match and register index within the window
    assign in_clk  = &bus_addr[ADDR_W-1:IDX_W];
    assign reg_idx = bus_addr[IDX_W-1:0];

    // Strobe qualifiers
    assign rd_act = ~bus_cs_n & ~bus_oe_n & bus_we_n;
    assign wr_act = ~bus_cs_n & ~bus_we_n;

    // Remember the write strobe so a held write acts once
    always_ff @(posedge clk) begin
        if (!rst_n) wr_act_q <= 1'b0;
        else        wr_act_q <= wr_act;
    end

    assign wr_fire     = wr_act & ~wr_act_q;
    assign clk_wr_fire = wr_fire & in_clk;

    // RAM pass-through below the clock window
    assign ram_sel   = ~bus_cs_n & ~in_clk;
    assign ram_we    = wr_act & ~in_clk;
    assign ram_addr  = bus_addr;
    assign ram_wdata = bus_wdata;
endmodule

// File: rtl/tkr_ctrl_byte.sv
// Control byte: holds the write-halt and read-halt flags and the century
// field, applies the century update rules, decides when the snapshot copy
// may refresh and emits the one-cycle load toward the counters.
// Assumes ctrl_wr is a single-cycle write event.
module tkr_ctrl_byte
    import tkr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [7:0]        wdata,
    input  logic              cnt_tick,
    input  logic [CENT_W-1:0] cnt_century,
    output logic              halt_w,
    output logic              halt_r,
    output logic [CENT_W-1:0] century,
    output logic              refresh,
    output logic              w_clear,
    output logic              ld_pulse,
    output logic [CENT_W-1:0] ld_century
);
    logic w_nx;
    logic r_nx;

    // Flag values after this cycle's write, if any
    assign w_nx    = ctrl_wr ? wdata[WHALT_BIT] : halt_w;
    assign r_nx    = ctrl_wr ? wdata[RHALT_BIT] : halt_r;
    assign w_clear = ctrl_wr & halt_w & ~wdata[WHALT_BIT];

    // Refresh only while running, never while a load is in flight
    assign refresh = cnt_tick & ~w_nx & ~r_nx & ~w_clear & ~ld_pulse;

    // Halt flags, century and load pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_w     <= 1'b0;
            halt_r     <= 1'b0;
            century    <= '0;
            ld_pulse   <= 1'b0;
            ld_century <= '0;
        end else begin
            halt_w   <= w_nx;
            halt_r   <= r_nx;
            ld_pulse <= w_clear;
            if (w_clear) begin
                century    <= wdata[CENT_W-1:0];
                ld_century <= wdata[CENT_W-1:0];
            end else if (refresh) begin
                century <= cnt_century;
            end
        end
    end
endmodule

// File: rtl/tkr_time_shadow.sv
// Snapshot copy of the seven time bytes: each byte takes a bus write or a
// counter refresh, the bus write having priority. The day byte never
// stores its top bit, which is supplied on read by the battery flag.
// Also captures the copy for the counter load.
module tkr_time_shadow
    import tkr_pkg::*;
#(
    parameter int NUM_CLK_REGS = 8,
    localparam int IDX_W       = $clog2(NUM_CLK_REGS),
    localparam int NUM_TIME    = NUM_CLK_REGS - 1,
    localparam int TIME_W      = NUM_TIME * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_wr,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [7:0]        wdata,
    input  logic              refresh,
    input  logic [TIME_W-1:0] cnt_time,
    input  logic              capture,
    output logic [TIME_W-1:0] shadow_time,
    output logic [TIME_W-1:0] ld_time
);
    for (genvar g = 0; g < NUM_TIME; g++) begin : g_byte
        localparam logic [7:0] KEEP = ((g + 1) == IDX_DAY) ? 8'h7F : 8'hFF;
        logic [7:0] byte_q;
        logic       hit;

        assign hit = byte_wr && (reg_idx == IDX_W'(g + 1));

        // Per-byte copy: bus write first, else counter refresh
        always_ff @(posedge clk) begin
            if (!rst_n)       byte_q <= '0;
            else if (hit)     byte_q <= wdata & KEEP;
            else if (refresh) byte_q <= cnt_time[g*BYTE_W +: BYTE_W] & KEEP;
        end

        assign shadow_time[g*BYTE_W +: BYTE_W] = byte_q;
    end

    // Capture the copy for the counter load
    always_ff @(posedge clk) begin
        if (!rst_n)       ld_time <= '0;
        else if (capture) ld_time <= shadow_time;
    end
endmodule

// File: rtl/tkr_read_mux.sv
// Read data selection: control byte, time bytes with the battery flag
// overlaid on the day byte, or RAM data. Drives zero when not reading.
module tkr_read_mux
    import tkr_pkg::*;
#(
    parameter int NUM_CLK_REGS = 8,
    localparam int IDX_W       = $clog2(NUM_CLK_REGS),
    localparam int NUM_TIME    = NUM_CLK_REGS - 1,
    localparam int TIME_W      = NUM_TIME * BYTE_W
) (
    input  logic              rd_act,
    input  logic              in_clk,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic              halt_w,
    input  logic              halt_r,
    input  logic [CENT_W-1:0] century,
    input  logic [TIME_W-1:0] shadow_time,
    input  logic              batt_low,
    input  logic [7:0]        ram_rdata,
    output logic [7:0]        rdata,
    output logic              rdata_oe
);
    assign rdata_oe = rd_act;

    // Select the addressed byte
    always_comb begin
        rdata = '0;
        if (rd_act) begin
            if (!in_clk) begin
                rdata = ram_rdata;
            end else if (reg_idx == IDX_W'(IDX_CTRL)) begin
                rdata = {halt_w, halt_r, century};
            end else begin
                for (int k = 0; k < NUM_TIME; k++) begin
                    if (reg_idx == IDX_W'(k + 1)) rdata = shadow_time[k*BYTE_W +: BYTE_W];
                end
                if (reg_idx == IDX_W'(IDX_DAY)) rdata[BATT_BIT] = ~batt_low;
            end
        end
    end
endmodule

// File: rtl/tkr_regfile.sv
// Double-buffered clock register interface. Maps the clock registers onto
// the top bytes of the address space, keeps a snapshot copy of the
// counters, implements the read-halt and write-halt flags and the deferred
// load, and passes lower addresses to a RAM port.
// Assumes one write event per CE/WE low period.
module tkr_regfile
    import tkr_pkg::*;
#(
    parameter int ADDR_W       = 15,
    parameter int NUM_CLK_REGS = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  bus_cs_n,
    input  logic                                  bus_oe_n,
    input  logic                                  bus_we_n,
    input  logic [ADDR_W-1:0]                     bus_addr,
    input  logic [7:0]                            bus_wdata,
    output logic [7:0]                            bus_rdata,
    output logic                                  bus_rdata_oe,
    output logic                                  ram_sel,
    output logic                                  ram_we,
    output logic [ADDR_W-1:0]                     ram_addr,
    output logic [7:0]                            ram_wdata,
    input  logic [7:0]                            ram_rdata,
    input  logic                                  cnt_tick,
    input  logic [(NUM_CLK_REGS-1)*BYTE_W-1:0]    cnt_time,
    input  logic [CENT_W-1:0]                     cnt_century,
    input  logic                                  batt_low,
    output logic                                  ld_pulse,
    output logic [(NUM_CLK_REGS-1)*BYTE_W-1:0]    ld_time,
    output logic [CENT_W-1:0]                     ld_century
);
    localparam int IDX_W  = $clog2(NUM_CLK_REGS);
    localparam int TIME_W = (NUM_CLK_REGS - 1) * BYTE_W;

    logic              in_clk;
    logic [IDX_W-1:0]  reg_idx;
    logic              rd_act;
    logic              wr_fire;
    logic              clk_wr_fire;
    logic              ctrl_wr;
    logic              halt_w;
    logic              halt_r;
    logic [CENT_W-1:0] century;
    logic              refresh;
    logic              w_clear;
    logic [TIME_W-1:0] shadow_time;

    assign ctrl_wr = clk_wr_fire && (reg_idx == IDX_W'(IDX_CTRL));

    tkr_bus_decode #(.ADDR_W(ADDR_W), .NUM_CLK_REGS(NUM_CLK_REGS)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .in_clk(in_clk), .reg_idx(reg_idx), .rd_act(rd_act),
        .wr_fire(wr_fire), .clk_wr_fire(clk_wr_fire),
        .ram_sel(ram_sel), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    tkr_ctrl_byte u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(bus_wdata),
        .cnt_tick(cnt_tick), .cnt_century(cnt_century),
        .halt_w(halt_w), .halt_r(halt_r), .century(century),
        .refresh(refresh), .w_clear(w_clear),
        .ld_pulse(ld_pulse), .ld_century(ld_century)
    );

    tkr_time_shadow #(.NUM_CLK_REGS(NUM_CLK_REGS)) u_shadow (
        .clk(clk), .rst_n(rst_n), .byte_wr(clk_wr_fire), .reg_idx(reg_idx),
        .wdata(bus_wdata), .refresh(refresh), .cnt_time(cnt_time),
        .capture(w_clear), .shadow_time(shadow_time), .ld_time(ld_time)
    );

    tkr_read_mux #(.NUM_CLK_REGS(NUM_CLK_REGS)) u_rmux (
        .rd_act(rd_act), .in_clk(in_clk), .reg_idx(reg_idx),
        .halt_w(halt_w), .halt_r(halt_r), .century(century),
        .shadow_time(shadow_time), .batt_low(batt_low), .ram_rdata(ram_rdata),
        .rdata(bus_rdata), .rdata_oe(bus_rdata_oe)
    );
endmodule

// File: rtl/tkr_regfile_chk.sv
// Property checker for tkr_regfile, attached by bind below.
module tkr_regfile_chk
    import tkr_pkg::*;
#(
    parameter int ADDR_W       = 15,
    parameter int NUM_CLK_REGS = 8,
    localparam int IDX_W       = $clog2(NUM_CLK_REGS),
    localparam int TIME_W      = (NUM_CLK_REGS - 1) * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_cs_n,
    input logic              bus_oe_n,
    input logic              bus_we_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_rdata,
    input logic              bus_rdata_oe,
    input logic              ram_we,
    input logic              batt_low,
    input logic              ld_pulse,
    input logic              wr_fire,
    input logic              halt_w,
    input logic              halt_r,
    input logic [TIME_W-1:0] shadow_time
);
    // R3
    rdata_oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_oe |-> (!bus_cs_n && !bus_oe_n && bus_we_n));

    // R2
    ram_we_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> !(&bus_addr[ADDR_W-1:IDX_W]));

    // R7
    ld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_pulse |=> !ld_pulse);

    // R7
    ld_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_pulse |-> ($past(halt_w) && !halt_w));

    // R5 R6
    frozen_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((halt_w || halt_r) && !wr_fire) |=> $stable(shadow_time));

    // R10
    batt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata_oe && (&bus_addr[ADDR_W-1:IDX_W]) &&
         bus_addr[IDX_W-1:0] == IDX_W'(IDX_DAY)) |-> (bus_rdata[BATT_BIT] == !batt_low));
endmodule

bind tkr_regfile tkr_regfile_chk #(.ADDR_W(ADDR_W), .NUM_CLK_REGS(NUM_CLK_REGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .bus_rdata_oe(bus_rdata_oe), .ram_we(ram_we), .batt_low(batt_low),
    .ld_pulse(ld_pulse), .wr_fire(wr_fire), .halt_w(halt_w), .halt_r(halt_r),
    .shadow_time(shadow_time)
);

// File: tb/tkr_regfile_tb.sv
module tkr_regfile_tb;
    localparam int CLK_PERIOD = 10;
    localparam int OP_WR = 0, OP_RD = 1, OP_TK = 2;

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [7:0]  exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 16'h0000, 8'h10, 8'h00, 8'd4},   // R4 tick
        '{2'd1, 16'h7FF9, 8'h00, 8'h10, 8'd4},   // R4 seconds refreshed
        '{2'd1, 16'h7FFF, 8'h00, 8'h16, 8'd1},   // R1 year
        '{2'd1, 16'h7FFB, 8'h00, 8'h12, 8'd1},   // R1 hours
        '{2'd1, 16'h7FFC, 8'h00, 8'h93, 8'd10},  // R10 day with flag
        '{2'd1, 16'h7FF8, 8'h00, 8'h10, 8'd1},   // R1 control
        '{2'd0, 16'h7FF8, 8'h40, 8'h00, 8'd8},   // R8 set read-halt
        '{2'd1, 16'h7FF8, 8'h00, 8'h50, 8'd8},   // R8 century kept
        '{2'd2, 16'h0000, 8'h20, 8'h00, 8'd5},   // R5 tick while halted
        '{2'd1, 16'h7FF9, 8'h00, 8'h10, 8'd5},   // R5 frozen
        '{2'd0, 16'h7FF8, 8'h00, 8'h00, 8'd9},   // R9 clear read-halt
        '{2'd1, 16'h7FF8, 8'h00, 8'h10, 8'd9},   // R9 century kept
        '{2'd2, 16'h0000, 8'h30, 8'h00, 8'd5},   // R5 tick after release
        '{2'd1, 16'h7FF9, 8'h00, 8'h30, 8'd5},
        '{2'd1, 16'h7FF8, 8'h00, 8'h30, 8'd5},
        '{2'd0, 16'h7FF8, 8'h80, 8'h00, 8'd8},   // R8 set write-halt
        '{2'd0, 16'h7FF9, 8'h45, 8'h00, 8'd6},   // R6 load seconds
        '{2'd0, 16'h7FFF, 8'h99, 8'h00, 8'd6},   // R6 load year
        '{2'd2, 16'h0000, 8'h50, 8'h00, 8'd6},   // R6 tick ignored
        '{2'd1, 16'h7FF9, 8'h00, 8'h45, 8'd6},
        '{2'd1, 16'h7FFF, 8'h00, 8'h99, 8'd6},
        '{2'd1, 16'h7FFA, 8'h00, 8'h31, 8'd6},
        '{2'd1, 16'h7FF8, 8'h00, 8'hB0, 8'd8}    // R8 century kept under write-halt
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs_n = 1'b1, bus_oe_n = 1'b1, bus_we_n = 1'b1;
    logic [14:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rdata_oe;
    logic        ram_sel, ram_we;
    logic [14:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = '0;
    logic        cnt_tick = 1'b0;
    logic [55:0] cnt_time = '0;
    logic [5:0]  cnt_century = '0;
    logic        batt_low = 1'b0;
    logic        ld_pulse;
    logic [55:0] ld_time;
    logic [5:0]  ld_century;

    int n_checks = 0;
    int n_errors = 0;
    int n_loads  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    tkr_regfile u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count load pulses and watch for a hung run
    always @(posedge clk) begin
        cycles++;
        if (rst_n && ld_pulse) n_loads++;
        if (cycles > 20000 && !done) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_read(input logic [14:0] a, output logic [7:0] d, output logic en);
        @(negedge clk);
        bus_addr = a; bus_cs_n = 1'b0; bus_oe_n = 1'b0; bus_we_n = 1'b1;
        #1;
        d = bus_rdata; en = bus_rdata_oe;
        bus_cs_n = 1'b1; bus_oe_n = 1'b1;
    endtask

    task automatic bus_write(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_cs_n = 1'b0; bus_we_n = 1'b0;
        @(negedge clk);
        bus_cs_n = 1'b1; bus_we_n = 1'b1;
    endtask

    function automatic logic [55:0] time_of(input logic [7:0] b);
        logic [55:0] t;
        for (int k = 0; k < 7; k++) t[k*8 +: 8] = b + 8'(k);
        return t;
    endfunction

    task automatic tick(input logic [7:0] b);
        @(negedge clk);
        cnt_time = time_of(b); cnt_century = b[5:0]; cnt_tick = 1'b1;
        @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    initial begin
        logic [7:0] d;
        logic       en;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 ld_pulse in reset", ld_pulse, 0);
        rst_n = 1'b1;
        bus_read(15'h7FF8, d, en);
        check("R11 control after reset", d, 8'h00);
        bus_read(15'h7FF9, d, en);
        check("R11 seconds after reset", d, 8'h00);
        check("R11 ld_pulse after reset", ld_pulse, 0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            case (int'(VECS[i].op))
                OP_WR: bus_write(VECS[i].addr[14:0], VECS[i].data);
                OP_TK: tick(VECS[i].data);
                default: begin
                    bus_read(VECS[i].addr[14:0], d, en);
                    check($sformatf("R%0d vector %0d", VECS[i].req, i), d, VECS[i].exp);
                end
            endcase
        end
        check("R6 no load while write-halted", n_loads, 0);
        check("R9 no load on read-halt release", n_loads, 0);

        // R7 release write-halt with century 07h
        bus_write(15'h7FF8, 8'h07);
        #1;
        check("R7 ld_pulse raised", ld_pulse, 1);
        check("R7 ld_time", ld_time, 56'h99353433323145);
        check("R7 ld_century", ld_century, 6'h07);
        @(negedge clk); #1;
        check("R7 ld_pulse one cycle", ld_pulse, 0);
        bus_read(15'h7FF8, d, en);
        check("R7 century from release write", d, 8'h07);
        check("R7 single load", n_loads, 1);

        // R4 refresh lands one cycle after the tick
        @(negedge clk);
        cnt_time = time_of(8'h60); cnt_century = 6'h20; cnt_tick = 1'b1;
        bus_addr = 15'h7FF9; bus_cs_n = 1'b0; bus_oe_n = 1'b0; bus_we_n = 1'b1;
        #1;
        check("R4 old value in tick cycle", bus_rdata, 8'h45);
        @(negedge clk);
        cnt_tick = 1'b0;
        #1;
        check("R4 new value after tick", bus_rdata, 8'h60);
        bus_cs_n = 1'b1; bus_oe_n = 1'b1;

        // R10 battery flag
        batt_low = 1'b1;
        bus_read(15'h7FFC, d, en);
        check("R10 flag low with battery low", d, 8'h63);
        batt_low = 1'b0;
        bus_write(15'h7FFC, 8'hFF);
        bus_read(15'h7FFC, d, en);
        check("R10 flag good after write", d, 8'hFF);
        batt_low = 1'b1;
        bus_read(15'h7FFC, d, en);
        check("R10 write did not set flag", d, 8'h7F);
        batt_low = 1'b0;

        // R2 RAM pass-through
        @(negedge clk);
        bus_addr = 15'h0100; bus_wdata = 8'h5A; bus_cs_n = 1'b0; bus_we_n = 1'b0;
        #1;
        check("R2 ram_we on low write", ram_we, 1);
        check("R2 ram_sel on low write", ram_sel, 1);
        check("R2 ram_addr", ram_addr, 15'h0100);
        check("R2 ram_wdata", ram_wdata, 8'h5A);
        @(negedge clk);
        bus_addr = 15'h7FFA; bus_wdata = 8'h31;
        #1;
        check("R2 no ram_we on clock write", ram_we, 0);
        bus_cs_n = 1'b1; bus_we_n = 1'b1;
        ram_rdata = 8'h3C;
        bus_read(15'h0100, d, en);
        check("R2 ram read data", d, 8'h3C);
        check("R3 oe on valid read", en, 1);

        // R3 read enable gating
        @(negedge clk);
        bus_addr = 15'h0200; bus_cs_n = 1'b0; bus_oe_n = 1'b0; bus_we_n = 1'b0;
        #1;
        check("R3 no drive during write", bus_rdata_oe, 0);
        bus_cs_n = 1'b1; bus_we_n = 1'b1;
        #1;
        check("R3 no drive when deselected", bus_rdata_oe, 0);
        bus_oe_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule